// File: doc/BRIEF.md
# Recirculating Serial Word Store

This block is one storage leaf of a tree-shaped serial memory. It holds a single word in a ring of shift stages that moves by one position on every clock. The bit that leaves the front of the ring passes through a two-way selector and re-enters at the back. The selector either returns the same bit, so the word is kept, or takes a fresh bit from the serial input, so the word is overwritten. Address decoding happens upstream. When this leaf is the target, the select line goes high. While it is high, the serial input carries an opcode bit and then one data slot per word bit.

A free-running phase counter tracks which word bit sits at the front of the ring. A transaction can only begin on a frame boundary, so the first slot after the opcode meets bit 0. Reads and writes both take the word width in slots. A write replaces the word bit by bit, LSB first. A read puts each stored bit on a registered output while the ring recirculates it unchanged. The output is zero at all other times.

Top module: `rws_leaf`

## Requirements
- R1: While reset is asserted and after its release, `dataOut` is 0 and the stored word is all zeros, so a read right after reset returns 0.
- R2: The ring shifts on every clock. When no write strobe is active, each bit that leaves the front is re-entered unchanged, so a stored word survives any number of idle cycles.
- R3: The phase counter is cleared by reset and advances on every clock, with period `WIDTH`. Counting clock edges after reset release from 0, a transaction opens on edge n only if n mod `WIDTH` = `WIDTH`-1, `selIn` is 1, and `selIn` was 0 on the previous edge. The `adIn` value on that edge is the opcode: 1 = write, 0 = read.
- R4: After a write opcode, the `adIn` values on the next `WIDTH` edges replace word bits 0, 1, … `WIDTH`-1 in that order, provided `selIn` stays 1.
- R5: After a read opcode, bit k of the stored word appears on `dataOut` in the cycle after slot k (k = 0 first), so the order matches the order of writing. The word is written back unchanged, so a second read returns the same value. `adIn` is ignored during read slots.
- R6: `dataOut` is 0 during idle cycles, during opcode cycles and during write slots.
- R7: A rising `selIn` on any other phase opens no transaction, even if `selIn` stays high across later frame boundaries. `adIn` has no effect while no transaction is open.
- R8: If `selIn` drops during the slots, the transaction ends at once. Bits already written are kept, and the remaining bits keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selIn | input | 1 | Serial select run for this leaf |
| adIn | input | 1 | Serial opcode/data stream |
| dataOut | output | 1 | Serial read data, zero when not reading |

## Verification
The main function is exercised with a table of write/read pairs that includes all-ones, all-zeros, words with only the end bits set, and mixed patterns. These words expose any rotation, bit reversal or stuck stage in the ring. Repeated reads and idle gaps whose length is not a multiple of the width separate a true recirculating loop from one that drifts or loses data. A select raised off the frame boundary, and a select dropped part way through a write, check frame alignment and slot-by-slot enabling. A read right after reset checks clearing.

// File: rtl/rws_pkg.sv
package rws_pkg;

  // Per-cycle strobes from control to the storage ring.
  typedef struct packed {
    logic writeEn;  // take the incoming serial bit into the ring
    logic readEn;   // present the ring's front bit on the output
  } strobe_t;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_READ  = 2'd1,
    M_WRITE = 2'd2
  } mode_e;

endpackage

// File: rtl/rws_phase.sv
module rws_phase #(
  parameter int WIDTH = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [$clog2(WIDTH)-1:0] phase,
  output logic                     lastSlot
);

  localparam int PW = $clog2(WIDTH);
  localparam logic [PW-1:0] LAST = PW'(WIDTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign lastSlot = (phase == LAST);

  // R3: the phase wraps to zero after the last slot of a frame
  p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lastSlot |=> (phase == '0));

  // R3: outside the wrap the phase advances by exactly one
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lastSlot && $past(rst_n)) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/rws_ctrl.sv
module rws_ctrl
  import rws_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    selIn,
  input  logic    adIn,
  input  logic    lastSlot,
  output strobe_t strobe
);

  mode_e mode;
  logic  selPrev;
  logic  busy;
  logic  accept;

  assign busy   = (mode != M_IDLE);
  assign accept = !busy && selIn && !selPrev && lastSlot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selPrev <= 1'b0;
    end else begin
      selPrev <= selIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IDLE;
    end else begin
      unique case (mode)
        M_IDLE: begin
          if (accept) begin
            mode <= adIn ? M_WRITE : M_READ;
          end
        end
        M_READ, M_WRITE: begin
          if (!selIn || lastSlot) begin
            mode <= M_IDLE;
          end
        end
        default: mode <= M_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.writeEn = (mode == M_WRITE) && selIn;
    strobe.readEn  = (mode == M_READ)  && selIn;
  end

  // R3: a transaction only opens on a fresh select at the frame boundary
  p_open_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(lastSlot && selIn && !selPrev));

  // R4: a transaction closes after the final slot of the frame
  p_close_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lastSlot) |=> !busy);

  // R8: losing select ends the transaction at once
  p_abort_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !selIn) |=> !busy);

endmodule

// File: rtl/rws_loop.sv
module rws_loop
  import rws_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adIn,
  input  strobe_t strobe,
  output logic    dataOut
);

  logic [WIDTH-1:0] ringQ;
  logic             muxOut;
  logic             dataOutQ;

  // Entry selector: new serial bit on a write slot, otherwise recirculate.
  assign muxOut = strobe.writeEn ? adIn : ringQ[0];

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == WIDTH - 1) begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n) ringQ[i] <= 1'b0;
          else        ringQ[i] <= muxOut;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) ringQ[i] <= 1'b0;
          else        ringQ[i] <= ringQ[i+1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) dataOutQ <= 1'b0;
    else        dataOutQ <= strobe.readEn & ringQ[0];
  end

  assign dataOut = dataOutQ;

  // R2: without a write strobe the front bit re-enters at the tail
  p_recirculate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.writeEn |=> (ringQ[WIDTH-1] == $past(ringQ[0])));

  // R4: a write slot loads the serial input at the tail
  p_write_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.writeEn |=> (ringQ[WIDTH-1] == $past(adIn)));

  // R5: the bit shown on a read is the same bit written back
  p_read_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.readEn |=> (ringQ[WIDTH-1] == dataOut));

  // R6: the output stays low whenever no read slot is active
  p_quiet_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.readEn |=> (dataOut == 1'b0));

endmodule

// File: rtl/rws_leaf.sv
module rws_leaf
  import rws_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic selIn,
  input  logic adIn,
  output logic dataOut
);

  localparam int PW = $clog2(WIDTH);

  logic [PW-1:0] phase;
  logic          lastSlot;
  strobe_t       strobe;

  rws_phase #(.WIDTH(WIDTH)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .lastSlot (lastSlot)
  );

  rws_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .selIn    (selIn),
    .adIn     (adIn),
    .lastSlot (lastSlot),
    .strobe   (strobe)
  );

  rws_loop #(.WIDTH(WIDTH)) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .adIn    (adIn),
    .strobe  (strobe),
    .dataOut (dataOut)
  );

  // R6: write and read slots never coincide
  p_single_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.writeEn && strobe.readEn));

endmodule

// File: tb/test_rws_leaf.sv
`timescale 1ns/1ps
module test_rws_leaf;

  localparam int W = 12;

  typedef struct packed {
    logic         isWr;
    logic [W-1:0] word;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 12'hA5A}, '{1'b0, 12'h000},
    '{1'b1, 12'hFFF}, '{1'b0, 12'h000},
    '{1'b0, 12'h000},
    '{1'b1, 12'h000}, '{1'b0, 12'h000},
    '{1'b1, 12'h801}, '{1'b0, 12'h000},
    '{1'b1, 12'h123}, '{1'b0, 12'h000},
    '{1'b1, 12'h5A3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic selIn = 1'b0;
  logic adIn = 1'b0;
  logic dataOut;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] model = '0;
  logic [W-1:0] got;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  rws_leaf #(.WIDTH(W)) i_rws_leaf (
    .clk     (clk),
    .rst_n   (rst_n),
    .selIn   (selIn),
    .adIn    (adIn),
    .dataOut (dataOut)
  );

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One framed transaction; select held for 'len' slots.
  task automatic doTxn(input bit isWr, input logic [W-1:0] word,
                       input int len, output logic [W-1:0] rd);
    rd = '0;
    selIn = 1'b0;
    @(negedge clk);
    while ((cyc % W) != W - 1) @(negedge clk);
    selIn = 1'b1;
    adIn  = isWr;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      if (k > 0) begin
        if (isWr) check(dataOut == 1'b0, "R6 write slot out", W'(dataOut), '0);
        else      rd[k-1] = dataOut;
      end
      selIn = (k < len);
      adIn  = word[k];
    end
    @(negedge clk);
    if (isWr) check(dataOut == 1'b0, "R6 write slot out", W'(dataOut), '0);
    else      rd[W-1] = dataOut;
    selIn = 1'b0;
    adIn  = 1'b0;
    @(negedge clk);
    check(dataOut == 1'b0, "R6 after transaction", W'(dataOut), '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      adIn = ~adIn;  // R7: stream toggles with select low
      check(dataOut == 1'b0, "R6 idle out", W'(dataOut), '0);
    end
    adIn = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dataOut == 1'b0, "R1 out in reset", W'(dataOut), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dataOut == 1'b0, "R1 out after reset", W'(dataOut), '0);

    // R1: stored word cleared by reset
    doTxn(1'b0, 12'hFFF, W, got);
    check(got == '0, "R1 read after reset", got, '0);

    // Table walk: writes update the model, reads compare (R4, R5)
    foreach (VECS[i]) begin
      doTxn(VECS[i].isWr, VECS[i].word, W, got);
      if (VECS[i].isWr) model = VECS[i].word;
      else check(got == model, "R4/R5 table read", got, model);
    end

    // R2: idle gaps not a multiple of W keep the word
    idle(7);
    doTxn(1'b0, 12'h000, W, got);
    check(got == 12'h5A3, "R2 after 7 idle", got, 12'h5A3);
    idle(29);
    doTxn(1'b0, 12'hFFF, W, got);
    check(got == 12'h5A3, "R2 after 29 idle, R5 repeat read", got, 12'h5A3);

    // R7: select raised off the frame boundary, held across a boundary
    selIn = 1'b0;
    @(negedge clk);
    while ((cyc % W) != 3) @(negedge clk);
    selIn = 1'b1;
    adIn  = 1'b1;
    for (int k = 0; k < 2 * W; k++) begin
      @(negedge clk);
      adIn = 1'b0;
      check(dataOut == 1'b0, "R7 misphased out", W'(dataOut), '0);
    end
    selIn = 1'b0;
    doTxn(1'b0, 12'h000, W, got);
    check(got == 12'h5A3, "R7 misphased ignored", got, 12'h5A3);

    // R3: opcode bit selects mode; 1 writes
    doTxn(1'b1, 12'hC3C, W, got);
    doTxn(1'b0, 12'h000, W, got);
    check(got == 12'hC3C, "R3 opcode write then read", got, 12'hC3C);

    // R8: select dropped after 5 write slots
    doTxn(1'b1, 12'hFFF, W, got);
    doTxn(1'b1, 12'h000, 5, got);
    doTxn(1'b0, 12'h000, W, got);
    check(got == 12'hFE0, "R8 partial write", got, 12'hFE0);

    // R8: read aborted early leaves word intact
    doTxn(1'b0, 12'h000, 4, got);
    check(got == 12'h000, "R8 aborted read bits", got & 12'hFF0, 12'h000);
    doTxn(1'b0, 12'h000, W, got);
    check(got == 12'hFE0, "R8 word kept after aborted read", got, 12'hFE0);

    // R1: reset mid-life clears the word
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(dataOut == 1'b0, "R1 out in second reset", W'(dataOut), '0);
    rst_n = 1'b1;
    doTxn(1'b0, 12'h000, W, got);
    check(got == '0, "R1 read after second reset", got, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule